// File: doc/BRIEF.md
# I/O Access Trap Monitor

This block watches host I/O cycles. Each cycle arrives as a 16-bit address with a valid strobe. The block compares every cycle against ten trap windows: two programmable windows and eight fixed windows that cover legacy peripheral addresses. Reads and writes are trapped alike, so the cycle direction is not an input.

When an enabled window is hit, the block sets a sticky status bit. If the matching event-mask bit is also set, it raises a one-clock power-management event pulse. The block never blocks, claims or emulates the cycle it has trapped; it only observes.

Firmware sets up the windows, enables, masks and status through a small byte-wide configuration register file. Status bits are cleared by writing ones to them. A software request register lets firmware raise the same kind of event without an I/O cycle.

Top module: `io_trap_monitor`

## Requirements
- R1: After a synchronous active-low reset every register reads 0x00 and `pm_event` is low.
- R2: Register map at `cfg_addr`:
  - 0x0 is trap-0 control. Bit 1 is base bit 1, bits 5:3 are the mask shift, and bit 2 always reads 0, so a write is kept under mask 0xFB.
  - 0x1 holds trap-0 base bits 9:2.
  - 0x2 and 0x3 hold the trap-1 base, low byte then high byte.
  - 0x4 and 0x5 are window enables for group A and group B.
  - 0x6 and 0x7 are event masks for group A and group B.
  - 0x8 and 0x9 are status for group A and group B.
  - 0xA is the software request register. It reads as zero, as do all unused offsets.
- R3: Trap 0 (group A bit 6) hits when the address lies in [base, base+0x80) and the address low byte equals the base low byte with the low N bits ignored, where N is the shift field.
- R4: Trap 1 (group A bit 5) is a 0x80-byte window from its 16-bit base with a full low-byte compare, so it hits only on the exact base address.
- R5: Fixed 8-byte windows report in group A. 0x378 and 0x278 share bit 4, 0x3F8 is bit 3, 0x2F8 is bit 2, 0x1F0 is bit 1 and 0x170 is bit 0.
- R6: Single-byte windows at 0x060 and 0x064 share group B bit 3.
- R7: A window sets its status bit only while its window-enable bit is 1.
- R8: A hit raises `pm_event` for exactly one clock, in the cycle after the I/O cycle, only if the event-mask bit of that status bit is 1. A hit whose event-mask bit is 0 still sets status.
- R9: Status bits stay set until a write to the status register carries a 1 in that bit position. Bits written as 0 are kept.
- R10: Writing the software request register with bit 1 set sets group B status bit 0. It also pulses `pm_event` in the next cycle if group B window-enable bit 0 is 1.
- R11: Enables, masks and bases are used combinationally. A change written in one cycle governs an I/O cycle in the very next cycle.
- R12: If a hit and a write-one clear of the same status bit fall in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` (combinational) |
| io_valid | input | 1 | Host I/O cycle present this clock |
| io_addr | input | 16 | Host I/O address |
| pm_event | output | 1 | One-clock power-management event |

## Verification
The bound checker watches the following on every cycle:
- No event appears without a preceding I/O cycle or software request.
- A status bit observed at the configuration port never falls without a write.
- A status bit only rises after an I/O cycle.
- A full write-one clear empties group A.
- The trap-0 control register never shows bit 2.

Only the bench's scenarios can show the address arithmetic of each window:
- the masked low-byte compare of trap 0 at the edges of its window;
- the exact-match behaviour of trap 1;
- the shared enable bits;
- the enable-change timing;
- precedence between a hit and a clear in the same cycle.

// File: rtl/io_trap_pkg.sv
// Shared constants for the I/O trap monitor: register offsets, the
// write mask of the trap-0 control register and the fixed legacy windows.
// Assumes a 16-entry configuration space and byte-wide registers.
package io_trap_pkg;
    localparam int CFG_AW  = 4;
    localparam int NREG    = 1 << CFG_AW;
    localparam int NFIX    = 8;
    localparam int PROG_SZ = 128;

    localparam logic [CFG_AW-1:0] A_T0CTL = 4'h0;
    localparam logic [CFG_AW-1:0] A_T0HI  = 4'h1;
    localparam logic [CFG_AW-1:0] A_T1LO  = 4'h2;
    localparam logic [CFG_AW-1:0] A_T1HI  = 4'h3;
    localparam logic [CFG_AW-1:0] A_WENA  = 4'h4;
    localparam logic [CFG_AW-1:0] A_WENB  = 4'h5;
    localparam logic [CFG_AW-1:0] A_EVMA  = 4'h6;
    localparam logic [CFG_AW-1:0] A_EVMB  = 4'h7;
    localparam logic [CFG_AW-1:0] A_STSA  = 4'h8;
    localparam logic [CFG_AW-1:0] A_STSB  = 4'h9;
    localparam logic [CFG_AW-1:0] A_SOFT  = 4'hA;

    localparam logic [7:0] T0CTL_KEEP = 8'hFB;

    // Base address of fixed window i (0..5 are 8 bytes wide, 6..7 are 1 byte wide).
    function automatic logic [15:0] fix_base(int i);
        case (i)
            0:       return 16'h0378;
            1:       return 16'h0278;
            2:       return 16'h03F8;
            3:       return 16'h02F8;
            4:       return 16'h01F0;
            5:       return 16'h0170;
            6:       return 16'h0064;
            default: return 16'h0060;
        endcase
    endfunction

    // Width in bytes of fixed window i.
    function automatic int fix_size(int i);
        return (i >= 6) ? 1 : 8;
    endfunction
endpackage

// File: rtl/trap_window.sv
// One address window comparator. It reports a hit when addr lies in
// [base, base+SIZE) and the address low byte equals the base low byte on
// every bit set in mask. A mask of zero gives a pure range check.
// Purely combinational; the caller adds the valid strobe and the enable.
module trap_window #(
    parameter int AW   = 16,
    parameter int SIZE = 8
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [7:0]    mask,
    output logic          hit
);
    logic [AW:0] a_ext;
    logic [AW:0] lo_ext;
    logic [AW:0] hi_ext;
    logic        in_range;
    logic        low_ok;

    // Range bounds are one bit wider so that a window near the top cannot wrap.
    always_comb begin
        a_ext    = {1'b0, addr};
        lo_ext   = {1'b0, base};
        hi_ext   = lo_ext + (AW+1)'(SIZE);
        in_range = (a_ext >= lo_ext) && (a_ext < hi_ext);
        low_ok   = ((addr[7:0] ^ base[7:0]) & mask) == 8'h00;
        hit      = in_range && low_ok;
    end
endmodule

// File: rtl/trap_regs.sv
// Configuration register file of the trap monitor. It holds the window
// bases, the enables, the event masks and the two sticky status registers.
// Status bits are set by hits and cleared by write-one; a set wins over a
// clear in the same cycle. Read data is combinational on cfg_addr.
module trap_regs
    import io_trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic [7:0]        set_a,
    input  logic [7:0]        set_b,
    output logic [7:0]        cfg_rdata,
    output logic [9:0]        t0_base,
    output logic [2:0]        t0_shift,
    output logic [15:0]       t1_base,
    output logic [6:0]        wen_a,
    output logic [6:0]        evm_a,
    output logic              kb_en,
    output logic              kb_evm,
    output logic              soft_en,
    output logic              soft_req
);
    logic [NREG-1:0] we;
    logic [7:0] r_t0ctl, r_t0hi, r_t1lo, r_t1hi;
    logic [7:0] r_wena, r_wenb, r_evma, r_evmb, r_stsa, r_stsb;
    logic [7:0] clr_a, clr_b;

    // Decode the write strobe into one enable per register.
    always_comb begin
        we       = cfg_wr ? (NREG'(1) << cfg_addr) : '0;
        clr_a    = we[A_STSA] ? cfg_wdata : 8'h00;
        clr_b    = we[A_STSB] ? cfg_wdata : 8'h00;
        soft_req = we[A_SOFT] & cfg_wdata[1];
    end

    // Plain read/write configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_t0ctl <= '0; r_t0hi <= '0; r_t1lo <= '0; r_t1hi <= '0;
            r_wena  <= '0; r_wenb <= '0; r_evma <= '0; r_evmb <= '0;
        end else begin
            if (we[A_T0CTL]) r_t0ctl <= cfg_wdata & T0CTL_KEEP;
            if (we[A_T0HI])  r_t0hi  <= cfg_wdata;
            if (we[A_T1LO])  r_t1lo  <= cfg_wdata;
            if (we[A_T1HI])  r_t1hi  <= cfg_wdata;
            if (we[A_WENA])  r_wena  <= cfg_wdata;
            if (we[A_WENB])  r_wenb  <= cfg_wdata;
            if (we[A_EVMA])  r_evma  <= cfg_wdata;
            if (we[A_EVMB])  r_evmb  <= cfg_wdata;
        end
    end

    // Sticky status: write-one clear, then hits (and the soft request) set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_stsa <= '0;
            r_stsb <= '0;
        end else begin
            r_stsa <= (r_stsa & ~clr_a) | set_a;
            r_stsb <= (r_stsb & ~clr_b) | set_b | {7'b0, soft_req};
        end
    end

    // Read-back multiplexer; the soft request and unused offsets read zero.
    always_comb begin
        case (cfg_addr)
            A_T0CTL: cfg_rdata = r_t0ctl;
            A_T0HI:  cfg_rdata = r_t0hi;
            A_T1LO:  cfg_rdata = r_t1lo;
            A_T1HI:  cfg_rdata = r_t1hi;
            A_WENA:  cfg_rdata = r_wena;
            A_WENB:  cfg_rdata = r_wenb;
            A_EVMA:  cfg_rdata = r_evma;
            A_EVMB:  cfg_rdata = r_evmb;
            A_STSA:  cfg_rdata = r_stsa;
            A_STSB:  cfg_rdata = r_stsb;
            default: cfg_rdata = 8'h00;
        endcase
    end

    // Field extraction for the comparators and the event logic.
    always_comb begin
        t0_base  = {r_t0hi, r_t0ctl[1], 1'b0};
        t0_shift = r_t0ctl[5:3];
        t1_base  = {r_t1hi, r_t1lo};
        wen_a    = r_wena[6:0];
        evm_a    = r_evma[6:0];
        kb_en    = r_wenb[3];
        kb_evm   = r_evmb[3];
        soft_en  = r_wenb[0];
    end
endmodule

// File: rtl/io_trap_monitor.sv
// Top of the I/O trap monitor. It compares each valid host I/O cycle with
// two programmable windows and eight fixed windows and records hits in
// sticky status. A hit whose event-mask bit is set, or a software request,
// produces a one-clock pm_event in the following cycle.
// Assumes at most one I/O cycle per clock; the direction is not considered.
module io_trap_monitor
    import io_trap_pkg::*;
#(
    parameter int IO_AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              io_valid,
    input  logic [IO_AW-1:0]  io_addr,
    output logic              pm_event
);
    logic [9:0]      t0_base;
    logic [2:0]      t0_shift;
    logic [15:0]     t1_base;
    logic [6:0]      wen_a, evm_a;
    logic            kb_en, kb_evm, soft_en, soft_req;
    logic [7:0]      t0_mask;
    logic            raw_t0, raw_t1;
    logic [NFIX-1:0] raw_fx;
    logic [7:0]      hit_a, hit_b;
    logic            ev_d;

    trap_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .set_a(hit_a), .set_b(hit_b),
        .cfg_rdata(cfg_rdata), .t0_base(t0_base), .t0_shift(t0_shift),
        .t1_base(t1_base), .wen_a(wen_a), .evm_a(evm_a), .kb_en(kb_en),
        .kb_evm(kb_evm), .soft_en(soft_en), .soft_req(soft_req)
    );

    // The trap-0 mask ignores the low t0_shift bits of the low byte.
    always_comb t0_mask = 8'hFF << t0_shift;

    trap_window #(.AW(IO_AW), .SIZE(PROG_SZ)) u_win_t0 (
        .addr(io_addr), .base(IO_AW'(t0_base)), .mask(t0_mask), .hit(raw_t0)
    );

    trap_window #(.AW(IO_AW), .SIZE(PROG_SZ)) u_win_t1 (
        .addr(io_addr), .base(IO_AW'(t1_base)), .mask(8'hFF), .hit(raw_t1)
    );

    for (genvar g = 0; g < NFIX; g++) begin : g_fix
        trap_window #(.AW(IO_AW), .SIZE(fix_size(g))) u_win_fx (
            .addr(io_addr), .base(IO_AW'(fix_base(g))), .mask(8'h00),
            .hit(raw_fx[g])
        );
    end

    // Gate raw window hits with the valid strobe and their enables.
    always_comb begin
        hit_a    = 8'h00;
        hit_b    = 8'h00;
        hit_a[6] = io_valid & wen_a[6] & raw_t0;
        hit_a[5] = io_valid & wen_a[5] & raw_t1;
        hit_a[4] = io_valid & wen_a[4] & (raw_fx[0] | raw_fx[1]);
        hit_a[3] = io_valid & wen_a[3] & raw_fx[2];
        hit_a[2] = io_valid & wen_a[2] & raw_fx[3];
        hit_a[1] = io_valid & wen_a[1] & raw_fx[4];
        hit_a[0] = io_valid & wen_a[0] & raw_fx[5];
        hit_b[3] = io_valid & kb_en & (raw_fx[6] | raw_fx[7]);
        ev_d     = (|(hit_a[6:0] & evm_a)) | (hit_b[3] & kb_evm)
                 | (soft_req & soft_en);
    end

    // Register the event so that it is a clean one-clock pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) pm_event <= 1'b0;
        else        pm_event <= ev_d;
    end
endmodule

// File: rtl/io_trap_monitor_chk.sv
// Property checker for io_trap_monitor, observing only its ports.
// Attached to every instance by the bind statement at the end of this file.
module io_trap_monitor_chk
    import io_trap_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [7:0]        cfg_wdata,
    input logic [7:0]        cfg_rdata,
    input logic              io_valid,
    input logic              pm_event
);
    p_no_idle_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_valid && !(cfg_wr && cfg_addr == A_SOFT)) |=> !pm_event);

    p_status_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == A_STSA && $past(cfg_addr == A_STSA) && !$past(cfg_wr))
        |-> (($past(cfg_rdata) & ~cfg_rdata) == 8'h00));

    p_status_needs_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == A_STSA && $past(cfg_addr == A_STSA) && $rose(cfg_rdata[3]))
        |-> $past(io_valid));

    p_full_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == A_STSA &&
         $past(cfg_wr && cfg_addr == A_STSA && cfg_wdata == 8'hFF && !io_valid))
        |-> (cfg_rdata == 8'h00));

    p_ctl_bit2_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == A_T0CTL) |-> !cfg_rdata[2]);
endmodule

bind io_trap_monitor io_trap_monitor_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_valid(io_valid),
    .pm_event(pm_event)
);

// File: tb/tb_io_trap_monitor.sv
// Bench for io_trap_monitor. A behavioural reference model is stepped on
// every clock and compared with pm_event and cfg_rdata; directed scenarios
// add named checks for each requirement.
module tb_io_trap_monitor;
    localparam int CLK_P = 10;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       cfg_wr = 0;
    logic [3:0] cfg_addr = 0;
    logic [7:0] cfg_wdata = 0;
    logic [7:0] cfg_rdata;
    logic       io_valid = 0;
    logic [15:0] io_addr = 0;
    logic       pm_event;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    io_trap_monitor dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_valid(io_valid),
        .io_addr(io_addr), .pm_event(pm_event)
    );

    always #(CLK_P/2) clk = ~clk;

    // ---------------- reference model ----------------
    logic [7:0] m_ctl, m_t0hi, m_t1lo, m_t1hi, m_wena, m_wenb, m_evma, m_evmb, m_stsa, m_stsb;
    bit e_pm = 0;

    function automatic logic [7:0] ref_a(int a);
        logic [7:0] r = 0;
        int b0 = m_t0hi * 4 + (m_ctl[1] ? 2 : 0);
        int n  = (m_ctl >> 3) & 7;
        if (m_wena[6] && a >= b0 && a < b0 + 128 && (((a & 255) >> n) == ((b0 & 255) >> n))) r[6] = 1;
        if (m_wena[5] && a == m_t1hi * 256 + m_t1lo) r[5] = 1;
        if (m_wena[4] && ((a >= 'h378 && a < 'h380) || (a >= 'h278 && a < 'h280))) r[4] = 1;
        if (m_wena[3] && a >= 'h3F8 && a < 'h400) r[3] = 1;
        if (m_wena[2] && a >= 'h2F8 && a < 'h300) r[2] = 1;
        if (m_wena[1] && a >= 'h1F0 && a < 'h1F8) r[1] = 1;
        if (m_wena[0] && a >= 'h170 && a < 'h178) r[0] = 1;
        return r;
    endfunction

    function automatic logic [7:0] ref_b(int a);
        return (m_wenb[3] && (a == 'h60 || a == 'h64)) ? 8'h08 : 8'h00;
    endfunction

    function automatic logic [7:0] ref_rd(logic [3:0] ad);
        case (ad)
            0: return m_ctl;  1: return m_t0hi; 2: return m_t1lo; 3: return m_t1hi;
            4: return m_wena; 5: return m_wenb; 6: return m_evma; 7: return m_evmb;
            8: return m_stsa; 9: return m_stsb;
            default: return 8'h00;
        endcase
    endfunction

    // Step the model on each edge, then compare the outputs shortly after.
    always @(posedge clk) begin
        logic [7:0] ha, hb;
        bit sf;
        if (!rst_n) begin
            m_ctl = 0; m_t0hi = 0; m_t1lo = 0; m_t1hi = 0; m_wena = 0;
            m_wenb = 0; m_evma = 0; m_evmb = 0; m_stsa = 0; m_stsb = 0; e_pm = 0;
        end else begin
            ha = io_valid ? ref_a(int'(io_addr)) : 8'h00;
            hb = io_valid ? ref_b(int'(io_addr)) : 8'h00;
            sf = cfg_wr && cfg_addr == 4'hA && cfg_wdata[1];
            e_pm = ((ha & m_evma) != 0) || ((hb & m_evmb) != 0) || (sf && m_wenb[0]);
            if (cfg_wr) case (cfg_addr)
                0: m_ctl  = cfg_wdata & 8'hFB;
                1: m_t0hi = cfg_wdata;  2: m_t1lo = cfg_wdata;  3: m_t1hi = cfg_wdata;
                4: m_wena = cfg_wdata;  5: m_wenb = cfg_wdata;  6: m_evma = cfg_wdata;
                7: m_evmb = cfg_wdata;  8: m_stsa = m_stsa & ~cfg_wdata;
                9: m_stsb = m_stsb & ~cfg_wdata;
                default: ;
            endcase
            m_stsa = m_stsa | ha;
            m_stsb = m_stsb | hb | {7'b0, sf};
        end
        #2;
        if (!done) begin
            n_chk++;
            if (pm_event !== e_pm) begin
                n_bad++;
                $display("FAIL R8 model pm_event actual=%0b expected=%0b at %0t", pm_event, e_pm, $time);
            end
            n_chk++;
            if (cfg_rdata !== ref_rd(cfg_addr)) begin
                n_bad++;
                $display("FAIL R2 model cfg_rdata[%0h] actual=%02h expected=%02h at %0t",
                         cfg_addr, cfg_rdata, ref_rd(cfg_addr), $time);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_wr = 0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] d);
        @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
    endtask

    task automatic io(logic [15:0] a);
        @(negedge clk); io_valid = 1; io_addr = a;
        @(negedge clk); io_valid = 0;
    endtask

    task automatic summary;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_P * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    // ---------------- directed scenarios ----------------
    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        rd(4'h0, d); chk("R1 ctl", d, 8'h00);
        rd(4'h8, d); chk("R1 stsA", d, 8'h00);
        rd(4'h4, d); chk("R1 wenA", d, 8'h00);
        chk("R1 pm_event", pm_event, 0);
        // R2: control register keeps mask 0xFB
        wr(4'h0, 8'hFF); rd(4'h0, d); chk("R2 ctl mask", d, 8'hFB);
        wr(4'h0, 8'h1A); wr(4'h1, 8'h20); rd(4'h1, d); chk("R2 t0hi", d, 8'h20);
        wr(4'h4, 8'h7F); wr(4'h6, 8'h7F); wr(4'h5, 8'h09); wr(4'h7, 8'h08);
        // R3: trap 0 base 0x082, shift 3
        io(16'h0085); chk("R3 pm hit", pm_event, 1);
        @(negedge clk); chk("R8 pulse one clock", pm_event, 0);
        rd(4'h8, d); chk("R3 sts", d, 8'h40);
        wr(4'h8, 8'hFF);
        io(16'h008A); chk("R3 masked miss pm", pm_event, 0);
        io(16'h0081); io(16'h0101);
        rd(4'h8, d); chk("R3 misses sts", d, 8'h00);
        // R4: trap 1 exact address
        wr(4'h2, 8'h34); wr(4'h3, 8'h12);
        io(16'h1234); chk("R4 pm", pm_event, 1);
        rd(4'h8, d); chk("R4 sts", d, 8'h20);
        wr(4'h8, 8'hFF); io(16'h1235);
        rd(4'h8, d); chk("R4 near miss", d, 8'h00);
        // R5: fixed windows
        io(16'h027F); rd(4'h8, d); chk("R5 0x27F", d, 8'h10);
        wr(4'h8, 8'hFF); io(16'h037C); rd(4'h8, d); chk("R5 0x37C", d, 8'h10);
        wr(4'h8, 8'hFF); io(16'h0380); rd(4'h8, d); chk("R5 0x380 miss", d, 8'h00);
        io(16'h03FF); io(16'h02F8); rd(4'h8, d); chk("R5 com", d, 8'h0C);
        io(16'h01F7); io(16'h0170); rd(4'h8, d); chk("R5 disk", d, 8'h0F);
        // R9: write-one clear affects only ones
        wr(4'h8, 8'h05); rd(4'h8, d); chk("R9 partial clear", d, 8'h0A);
        // R6: keyboard pair
        io(16'h0064); chk("R6 pm", pm_event, 1);
        io(16'h0065); chk("R6 miss pm", pm_event, 0);
        rd(4'h9, d); chk("R6 stsB", d, 8'h08);
        wr(4'h9, 8'hFF); io(16'h0060); rd(4'h9, d); chk("R6 0x60", d, 8'h08);
        // R7: disabled window leaves status alone
        wr(4'h4, 8'h7D); wr(4'h8, 8'hFF);
        io(16'h01F3); chk("R7 pm", pm_event, 0);
        rd(4'h8, d); chk("R7 sts", d, 8'h00);
        // R8: masked event still records status
        wr(4'h6, 8'h7B);
        io(16'h02FC); chk("R8 masked pm", pm_event, 0);
        rd(4'h8, d); chk("R8 sts", d, 8'h04);
        // R10: software request
        wr(4'hA, 8'h02); chk("R10 pm", pm_event, 1);
        rd(4'h9, d); chk("R10 stsB", d, 8'h09);
        wr(4'h5, 8'h08); wr(4'h9, 8'hFF);
        wr(4'hA, 8'h02); chk("R10 no pm", pm_event, 0);
        rd(4'h9, d); chk("R10 stsB only", d, 8'h01);
        wr(4'h9, 8'hFF); wr(4'hA, 8'hFD); rd(4'h9, d); chk("R10 bit1 clear", d, 8'h00);
        // R11: enable written one cycle, used by the cycle right after
        @(negedge clk); cfg_wr = 1; cfg_addr = 4'h4; cfg_wdata = 8'h7F;
        @(negedge clk); cfg_wr = 0; io_valid = 1; io_addr = 16'h01F0;
        @(negedge clk); io_valid = 0; chk("R11 pm", pm_event, 1);
        rd(4'h8, d); chk("R11 sts", d, 8'h06);
        wr(4'h8, 8'hFF);
        @(negedge clk); cfg_wr = 1; cfg_addr = 4'h4; cfg_wdata = 8'h7D;
        @(negedge clk); cfg_wr = 0; io_valid = 1; io_addr = 16'h01F1;
        @(negedge clk); io_valid = 0; chk("R11 disabled pm", pm_event, 0);
        rd(4'h8, d); chk("R11 disabled sts", d, 8'h00);
        // R12: set wins over same-cycle clear
        io(16'h0170);
        @(negedge clk); cfg_wr = 1; cfg_addr = 4'h8; cfg_wdata = 8'hFF;
        io_valid = 1; io_addr = 16'h03F8;
        @(negedge clk); cfg_wr = 0; io_valid = 0;
        rd(4'h8, d); chk("R12 set wins", d, 8'h08);
        repeat (3) @(negedge clk);
        summary();
    end
endmodule